// File: doc/BRIEF.md
# Accumulator Unit

This block is the working register of a small accumulator datapath. It holds a 16-bit accumulator together with a one-bit link flag (E). Each cycle it receives a set of operation strobes, a 16-bit memory operand and an 8-bit character from an input port. A per-bit adder-and-logic stage works out the next accumulator value. The register's separate load, increment and clear controls are then asserted according to the strobe that wins.

Arithmetic, logic, transfer, complement and rotate operations go through the load path. Clear and increment use the register's own controls. The link flag receives the adder carry and the bit that a rotate shifts out, and it has its own clear and complement strobes. Zero and sign flags are taken from the register for the decode logic that surrounds the block.

Top module: `acc_unit`

## Requirements
- R1: While rst_ni is low, acc_o reads 0 and e_o reads 0.
- R2: The AND strobe (op_i[0]) loads acc_o & dr_i on the next clock edge and leaves e_o unchanged.
- R3: The ADD strobe (op_i[1]) loads (acc_o + dr_i) mod 2^16 and writes the carry out of bit 15 into e_o.
- R4: The load-operand strobe (op_i[2]) loads dr_i. The load-input strobe (op_i[3]) writes inp_i into acc_o[7:0] and keeps acc_o[15:8].
- R5: The complement strobe (op_i[4]) inverts all 16 accumulator bits and leaves e_o unchanged.
- R6: The rotate-right strobe (op_i[5]) loads {e_o, acc_o[15:1]} and sets e_o to the old acc_o[0]. The rotate-left strobe (op_i[6]) loads {acc_o[14:0], e_o} and sets e_o to the old acc_o[15].
- R7: The clear strobe (op_i[7]) gives acc_o = 0 after the next edge. It overrides the increment strobe and every load strobe, and e_o stays unchanged.
- R8: The increment strobe (op_i[8]) adds 1 and wraps from 0xFFFF to 0x0000, with e_o unchanged. When it is present, any load strobe in the same cycle is ignored.
- R9: The clear-E strobe (op_i[9]) forces e_o to 0. The complement-E strobe (op_i[10]) inverts e_o. Neither strobe changes acc_o.
- R10: zero_o is 1 exactly when acc_o is 0, and sign_o equals acc_o[15].
- R11: When no strobe is asserted, acc_o and e_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 11 | Operation strobes, bit positions as given in R2 to R9 |
| dr_i | input | 16 | Memory operand |
| inp_i | input | 8 | Input character |
| acc_o | output | 16 | Accumulator |
| e_o | output | 1 | Link flag |
| zero_o | output | 1 | Accumulator is zero |
| sign_o | output | 1 | Accumulator bit 15 |

## Verification
The assertions assume that at most one of the seven load strobes (op_i[6:0]) is high in any cycle. They also assume that the two link-flag strobes are never high together, and never in the same cycle as ADD or a rotate. Directed stimulus combines clear and increment with a single load strobe so that the priority order is exercised without breaking these assumptions. The random phase drives exactly one strobe per cycle, which keeps it inside the same limits.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_N     = 11;
  localparam int OP_AND   = 0;
  localparam int OP_ADD   = 1;
  localparam int OP_LDR   = 2;
  localparam int OP_LINP  = 3;
  localparam int OP_COM   = 4;
  localparam int OP_SHR   = 5;
  localparam int OP_SHL   = 6;
  localparam int OP_CLR   = 7;
  localparam int OP_INC   = 8;
  localparam int OP_CLRE  = 9;
  localparam int OP_CME   = 10;

  typedef logic [OP_N-1:0] op_vec_t;

  typedef struct packed {
    logic f_and;
    logic f_add;
    logic f_ldr;
    logic f_linp;
    logic f_com;
    logic f_shr;
    logic f_shl;
  } ld_sel_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  op_vec_t op_i,
  output logic    clr_o,
  output logic    inr_o,
  output logic    ld_o,
  output ld_sel_t sel_o,
  output logic    clr_e_o,
  output logic    cme_o
);
  ld_sel_t raw;

  always_comb begin
    raw.f_and  = op_i[OP_AND];
    raw.f_add  = op_i[OP_ADD];
    raw.f_ldr  = op_i[OP_LDR];
    raw.f_linp = op_i[OP_LINP];
    raw.f_com  = op_i[OP_COM];
    raw.f_shr  = op_i[OP_SHR];
    raw.f_shl  = op_i[OP_SHL];
  end

  // clear > increment > load group
  assign clr_o   = op_i[OP_CLR];
  assign inr_o   = op_i[OP_INC] & ~op_i[OP_CLR];
  assign ld_o    = (|raw) & ~op_i[OP_CLR] & ~op_i[OP_INC];
  assign sel_o   = ld_o ? raw : '0;
  assign clr_e_o = op_i[OP_CLRE];
  assign cme_o   = op_i[OP_CME];
endmodule

// File: rtl/acc_slice.sv
module acc_slice
  import acc_pkg::*;
#(
  parameter bit HAS_INP = 1'b1
) (
  input  ld_sel_t sel_i,
  input  logic    dr_b_i,
  input  logic    ac_b_i,
  input  logic    inp_b_i,
  input  logic    ac_hi_i,
  input  logic    ac_lo_i,
  input  logic    c_i,
  output logic    d_o,
  output logic    c_o
);
  logic sum;

  assign sum = ac_b_i ^ dr_b_i ^ c_i;
  assign c_o = (ac_b_i & dr_b_i) | (c_i & (ac_b_i ^ dr_b_i));

  always_comb begin
    d_o = ac_b_i;
    if (sel_i.f_and)       d_o = ac_b_i & dr_b_i;
    else if (sel_i.f_add)  d_o = sum;
    else if (sel_i.f_ldr)  d_o = dr_b_i;
    else if (sel_i.f_linp) d_o = HAS_INP ? inp_b_i : ac_b_i;
    else if (sel_i.f_com)  d_o = ~ac_b_i;
    else if (sel_i.f_shr)  d_o = ac_hi_i;
    else if (sel_i.f_shl)  d_o = ac_lo_i;
  end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inr_i,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inr_i) q_o <= q_o + ONE;
    else if (ld_i)  q_o <= d_i;
  end

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> q_o == '0);
  assert_inc_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inr_i && !clr_i) |=> q_o == $past(q_o) + ONE);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inr_i && !ld_i) |=> $stable(q_o));
endmodule

// File: rtl/acc_eflag.sv
module acc_eflag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_e_i,
  input  logic cme_i,
  input  logic add_i,
  input  logic shr_i,
  input  logic shl_i,
  input  logic carry_i,
  input  logic ac_lsb_i,
  input  logic ac_msb_i,
  output logic e_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      e_o <= 1'b0;
    else if (clr_e_i) e_o <= 1'b0;
    else if (cme_i)   e_o <= ~e_o;
    else if (add_i)   e_o <= carry_i;
    else if (shr_i)   e_o <= ac_lsb_i;
    else if (shl_i)   e_o <= ac_msb_i;
  end

  assert_clr_e_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_e_i |=> !e_o);
  assert_cme_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cme_i && !clr_e_i) |=> e_o != $past(e_o));
  assert_e_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_e_i && !cme_i && !add_i && !shr_i && !shl_i) |=> $stable(e_o));
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_pkg::*;
#(
  parameter int W     = 16,
  parameter int IN_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_N-1:0] op_i,
  input  logic [W-1:0]    dr_i,
  input  logic [IN_W-1:0] inp_i,
  output logic [W-1:0]    acc_o,
  output logic            e_o,
  output logic            zero_o,
  output logic            sign_o
);
  logic          clr, inr, ld, clr_e, cme;
  ld_sel_t       sel;
  logic [W-1:0]  d_next;
  logic [W:0]    carry;

  acc_ctrl u_ctrl (
    .op_i    (op_i),
    .clr_o   (clr),
    .inr_o   (inr),
    .ld_o    (ld),
    .sel_o   (sel),
    .clr_e_o (clr_e),
    .cme_o   (cme)
  );

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hi_b, lo_b, inp_b;
    assign hi_b  = (i == W-1) ? e_o : acc_o[(i == W-1) ? i : i+1];
    assign lo_b  = (i == 0)   ? e_o : acc_o[(i == 0) ? i : i-1];
    if (i < IN_W) begin : g_in
      assign inp_b = inp_i[i];
    end else begin : g_noin
      assign inp_b = 1'b0;
    end
    acc_slice #(.HAS_INP(i < IN_W)) u_slice (
      .sel_i   (sel),
      .dr_b_i  (dr_i[i]),
      .ac_b_i  (acc_o[i]),
      .inp_b_i (inp_b),
      .ac_hi_i (hi_b),
      .ac_lo_i (lo_b),
      .c_i     (carry[i]),
      .d_o     (d_next[i]),
      .c_o     (carry[i+1])
    );
  end

  acc_reg #(.W(W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inr_i  (inr),
    .ld_i   (ld),
    .d_i    (d_next),
    .q_o    (acc_o)
  );

  acc_eflag u_eflag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_e_i  (clr_e),
    .cme_i    (cme),
    .add_i    (sel.f_add),
    .shr_i    (sel.f_shr),
    .shl_i    (sel.f_shl),
    .carry_i  (carry[W]),
    .ac_lsb_i (acc_o[0]),
    .ac_msb_i (acc_o[W-1]),
    .e_o      (e_o)
  );

  assign zero_o = ~|acc_o;
  assign sign_o = acc_o[W-1];

  // input constraint: one load strobe at a time; E strobes exclusive with E writers
  assert_ld_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(op_i[OP_SHL:OP_AND]));
  assert_e_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[OP_CLRE] || op_i[OP_CME]) |->
      (!(op_i[OP_CLRE] && op_i[OP_CME]) && !op_i[OP_ADD] && !op_i[OP_SHR] && !op_i[OP_SHL]));

  assert_and_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel.f_and |=> acc_o == ($past(acc_o) & $past(dr_i)));
  assert_add_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel.f_add |=> {e_o, acc_o} == {1'b0, $past(acc_o)} + {1'b0, $past(dr_i)});
  assert_linp_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel.f_linp |=> acc_o[W-1:IN_W] == $past(acc_o[W-1:IN_W]) && acc_o[IN_W-1:0] == $past(inp_i));
  assert_com_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel.f_com |=> acc_o == ~$past(acc_o));
  assert_shr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel.f_shr |=> {acc_o, e_o} == {$past(e_o), $past(acc_o)});
  assert_shl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel.f_shl |=> {e_o, acc_o} == {$past(acc_o), $past(e_o)});
  assert_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sign_o == acc_o[W-1] && zero_o == (acc_o == '0));
endmodule

// File: tb/acc_unit_bench.sv
module acc_unit_bench;
  localparam int B_AND = 0, B_ADD = 1, B_LDR = 2, B_LINP = 3, B_COM = 4, B_SHR = 5,
                 B_SHL = 6, B_CLR = 7, B_INC = 8, B_CLRE = 9, B_CME = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] op_i = '0;
  logic [15:0] dr_i = '0;
  logic [7:0]  inp_i = '0;
  logic [15:0] acc_o;
  logic        e_o, zero_o, sign_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct packed { logic [15:0] acc; logic e; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  logic [15:0] m_acc = '0;
  logic        m_e = 1'b0;

  always #2 clk = ~clk;

  acc_unit u_acc_unit (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .op_i   (op_i),
    .dr_i   (dr_i),
    .inp_i  (inp_i),
    .acc_o  (acc_o),
    .e_o    (e_o),
    .zero_o (zero_o),
    .sign_o (sign_o)
  );

  function automatic logic [10:0] bit_of(input int b);
    return 11'(1) << b;
  endfunction

  task automatic drive(input logic [10:0] op, input logic [15:0] dr, input logic [7:0] inp,
                       input string tag);
    logic [15:0] na;
    logic        ne;
    logic [16:0] s;
    @(negedge clk);
    op_i = op; dr_i = dr; inp_i = inp;
    na = m_acc; ne = m_e;
    if (op[B_CLR]) na = '0;
    else if (op[B_INC]) na = m_acc + 16'd1;
    else if (op[B_AND]) na = m_acc & dr;
    else if (op[B_ADD]) begin s = {1'b0, m_acc} + {1'b0, dr}; na = s[15:0]; ne = s[16]; end
    else if (op[B_LDR]) na = dr;
    else if (op[B_LINP]) na = {m_acc[15:8], inp};
    else if (op[B_COM]) na = ~m_acc;
    else if (op[B_SHR]) begin na = {m_e, m_acc[15:1]}; ne = m_acc[0]; end
    else if (op[B_SHL]) begin na = {m_acc[14:0], m_e}; ne = m_acc[15]; end
    if (op[B_CLRE]) ne = 1'b0;
    else if (op[B_CME]) ne = ~m_e;
    m_acc = na; m_e = ne;
    exp_q.push_back('{acc: na, e: ne});
    tag_q.push_back(tag);
  endtask

  // monitor: results settle one edge after the driving negedge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  x;
      string t;
      x = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (acc_o !== x.acc || e_o !== x.e || zero_o !== (x.acc == 16'd0) || sign_o !== x.acc[15]) begin
        n_bad++;
        $display("FAIL %s: acc=%h e=%b z=%b s=%b expected acc=%h e=%b z=%b s=%b", t,
                 acc_o, e_o, zero_o, sign_o, x.acc, x.e, (x.acc == 16'd0), x.acc[15]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (acc_o !== 16'd0 || e_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: acc=%h e=%b expected acc=0000 e=0", acc_o, e_o);
    end
    rst_ni = 1'b1;

    drive(bit_of(B_LDR), 16'h1234, 8'h00, "R4 load operand");
    drive(bit_of(B_AND), 16'h0FF0, 8'h00, "R2 and");
    drive(bit_of(B_ADD), 16'hFDD0, 8'h00, "R3 add carry to zero / R10");
    drive(bit_of(B_LDR), 16'h7FFF, 8'h00, "R4 load operand");
    drive(bit_of(B_ADD), 16'h0001, 8'h00, "R3 add no carry / R10 sign");
    drive(bit_of(B_LINP), 16'hFFFF, 8'hAB, "R4 load input low byte");
    drive(bit_of(B_COM), 16'h0000, 8'h00, "R5 complement");
    drive(bit_of(B_CME), 16'h0000, 8'h00, "R9 complement E");
    drive(bit_of(B_SHR), 16'h0000, 8'h00, "R6 rotate right");
    drive(bit_of(B_SHL), 16'h0000, 8'h00, "R6 rotate left");
    drive(bit_of(B_SHL), 16'h0000, 8'h00, "R6 rotate left");
    drive(bit_of(B_CLRE), 16'h0000, 8'h00, "R9 clear E");
    drive(11'd0, 16'hFFFF, 8'hFF, "R11 idle hold");
    drive(bit_of(B_LDR), 16'hFFFF, 8'h00, "R4 load operand");
    drive(bit_of(B_CME), 16'h0000, 8'h00, "R9 complement E");
    drive(bit_of(B_INC), 16'h0000, 8'h00, "R8 increment wrap, E kept / R10");
    drive(bit_of(B_INC) | bit_of(B_ADD), 16'h8000, 8'h00, "R8 increment beats add");
    drive(bit_of(B_INC) | bit_of(B_SHL), 16'h0000, 8'h00, "R8 increment beats rotate");
    drive(bit_of(B_CLR) | bit_of(B_INC) | bit_of(B_LDR), 16'h5555, 8'h00, "R7 clear wins");
    drive(bit_of(B_LDR), 16'h8001, 8'h00, "R4 load operand");
    drive(bit_of(B_CLR), 16'h0000, 8'h00, "R7 clear alone");
    drive(11'd0, 16'h0000, 8'h00, "R11 idle hold");

    for (int k = 0; k < 300; k++) begin
      int b;
      b = int'($urandom % 11);
      drive(bit_of(b), 16'($urandom), 8'($urandom), "R2-R9 random single strobe");
    end
    drive(11'd0, 16'h0000, 8'h00, "R11 idle hold");
    @(negedge clk);
    op_i = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule